// File: doc/BRIEF.md
# Read-First RAM Self-Test Sequencer

This block drives an external single-port synchronous RAM through a fixed four-step pattern at every address and judges the returned words. After a start pulse, it sweeps the addresses upward from zero. At each address it does four things: it writes a pseudo-random word, reads that word back, issues a read and a write together with a second pseudo-random word, and then reads once more. The combined cycle checks that the memory behaves as read-before-write, which means the old word must come back while the new word is stored.

The RAM's read data is expected a fixed number of clocks after the cycle that raised the read strobe. That number is set by the `RD_LAT` parameter: 1 for a plain synchronous array, or 2 when the array has an output register. The first disagreement between a returned word and the expected word does three things. It sets a sticky error flag. It freezes the address, the step, the expected word and the received word. Depending on `stop_on_error`, it either ends the sweep or lets it run to the last address. A done flag closes each sweep and holds until the next accepted start.

Top module: `rfram_selftest`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `done`, `pass`, `err`, `mem_rd` and `mem_wr` are all 0.
- R2: A start pulse seen while idle or done begins a sweep at address 0. Each address gets four back-to-back cycles at the same address, in this order: write only (`mem_wr`=1, `mem_rd`=0), read only, read and write together, read only. Addresses then rise by one up to 2^ADDR_W-1.
- R3: `mem_rd` and `mem_wr` are 0 in every cycle that does not perform that operation, including idle, the drain after the last address, and done.
- R4: The data words are the low DATA_W bits of a 16-bit LFSR. The LFSR steps on every clock: it shifts left by one, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. Because of this, the combined-cycle word of an address equals the first word of that address shifted left by two. The first word of the next address is the previous first word shifted left by four.
- R5: Read data is compared `RD_LAT` cycles after the cycle that issued the read. The first read must return the first word, the combined cycle must return the first word (read-first), and the last read must return the second word.
- R6: The first mismatch sets `err` and latches `fail_addr`, `fail_exp`, `fail_got` and `fail_step`. In `fail_step`, 1 means the read after the write, 2 means the combined cycle and 3 means the last read. Later mismatches change none of these values, and `err` stays set until a new sweep is accepted.
- R7: With `stop_on_error`=1, a mismatch ends the sweep. `done` rises on the next cycle, and no strobe is issued after that.
- R8: With `stop_on_error`=0, the sweep always covers every address, so exactly 2·2^ADDR_W write strobes are issued.
- R9: After the last address, once its final read has been compared, `done` rises and holds until a start is accepted. `pass` is 1 exactly when `done` is 1 and `err` is 0.
- R10: A start pulse during a sweep is ignored. The sweep neither restarts nor skips any address.
- R11: A start accepted after a failed sweep clears `err` and the captured failure fields, so a clean second sweep ends with `pass`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sweep when idle or done |
| stop_on_error | input | 1 | 1: end the sweep at the first mismatch |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rd | output | 1 | RAM read strobe |
| mem_wr | output | 1 | RAM write strobe |
| mem_rdata | input | DATA_W | RAM read data |
| done | output | 1 | Sweep finished or stopped |
| pass | output | 1 | Done with no mismatch |
| err | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_step | output | 2 | Step of the first mismatch (1, 2 or 3) |
| fail_exp | output | DATA_W | Expected word of the first mismatch |
| fail_got | output | DATA_W | Received word of the first mismatch |

## Verification
Two of the block's functions can fall in the same cycle. One is the comparison of a delayed read that is still in flight. The other is the issue of the next strobes, which includes the combined read/write cycle the read-first check depends on. The bench's RAM model has faults that can be switched on: it can return the new word on a collision, drop the collision write, or flip a bit on reads. These faults are placed at the first address, the last address and ranges in between. The bench predicts the failing address, step and the two words from the data it watched on the write bus. In stop mode it judges from the port activity that nothing issued after the mismatch escaped the halt.

// File: rtl/rfst_pkg.sv
package rfst_pkg;

  localparam int LFSR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_RD    = 3'd2,
    ST_RW    = 3'd3,
    ST_RD2   = 3'd4,
    ST_DRAIN = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_RAW   = 2'd1,
    STEP_COLL  = 2'd2,
    STEP_FINAL = 2'd3
  } step_t;

endpackage

// File: rtl/rfst_lfsr.sv
module rfst_lfsr #(
  parameter int          OUT_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] word
);
  import rfst_pkg::*;

  logic [LFSR_W-1:0] state_q, state_d;
  logic              fb;

  // Fibonacci form, taps 16,14,13,11 (maximal length)
  always_comb begin
    fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
    state_d = {state_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign word = state_q[OUT_W-1:0];

endmodule

// File: rtl/rfst_ctrl.sv
module rfst_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  input  logic [DATA_W-1:0] rnd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              iss_vld,
  output rfst_pkg::step_t   iss_step,
  output logic [DATA_W-1:0] iss_exp,
  output logic              clr,
  output logic              done
);
  import rfst_pkg::*;

  localparam int               CNT_W   = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);
  localparam logic [ADDR_W-1:0] LAST_A = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE_A  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  DRAIN0 = CNT_W'(RD_LAT - 1);
  localparam logic [CNT_W-1:0]  ONE_C  = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [DATA_W-1:0] word_a_q, word_b_q;
  logic              ld_a, ld_b;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    ld_a    = 1'b0;
    ld_b    = 1'b0;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    clr     = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_WR;
          addr_d  = '0;
          addr_en = 1'b1;
          clr     = 1'b1;
        end
      end
      ST_WR: begin
        ld_a    = 1'b1;
        state_d = halt ? ST_DONE : ST_RD;
      end
      ST_RD: begin
        state_d = halt ? ST_DONE : ST_RW;
      end
      ST_RW: begin
        ld_b    = 1'b1;
        state_d = halt ? ST_DONE : ST_RD2;
      end
      ST_RD2: begin
        if (halt) begin
          state_d = ST_DONE;
        end else if (addr_q == LAST_A) begin
          state_d = ST_DRAIN;
          cnt_d   = DRAIN0;
          cnt_en  = 1'b1;
        end else begin
          state_d = ST_WR;
          addr_d  = addr_q + ONE_A;
          addr_en = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (halt || cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          cnt_d  = cnt_q - ONE_C;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      word_a_q <= '0;
      word_b_q <= '0;
      cnt_q    <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q   <= addr_d;
      if (ld_a)    word_a_q <= rnd;
      if (ld_b)    word_b_q <= rnd;
      if (cnt_en)  cnt_q    <= cnt_d;
    end
  end

  // strobes and issue tag, decoded from the state register
  always_comb begin
    mem_wr    = (state_q == ST_WR) || (state_q == ST_RW);
    mem_rd    = (state_q == ST_RD) || (state_q == ST_RW) || (state_q == ST_RD2);
    mem_wdata = mem_wr ? rnd : '0;
    mem_addr  = addr_q;
    iss_vld   = mem_rd;
    iss_exp   = (state_q == ST_RD2) ? word_b_q : word_a_q;
    unique case (state_q)
      ST_RD:   iss_step = STEP_RAW;
      ST_RW:   iss_step = STEP_COLL;
      ST_RD2:  iss_step = STEP_FINAL;
      default: iss_step = STEP_NONE;
    endcase
    done = (state_q == ST_DONE);
  end

endmodule

// File: rtl/rfst_score.sv
module rfst_score #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stop_on_error,
  input  logic              iss_vld,
  input  rfst_pkg::step_t   iss_step,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              halt,
  output logic              err,
  output logic [ADDR_W-1:0] fail_addr,
  output rfst_pkg::step_t   fail_step,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  import rfst_pkg::*;

  localparam int TAIL = RD_LAT - 1;

  logic              p_vld  [RD_LAT];
  step_t             p_step [RD_LAT];
  logic [ADDR_W-1:0] p_addr [RD_LAT];
  logic [DATA_W-1:0] p_exp  [RD_LAT];
  logic              mism;
  logic              cap;

  // tag delay line, one stage per cycle of read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < RD_LAT; k++) begin
        p_vld[k]  <= 1'b0;
        p_step[k] <= STEP_NONE;
        p_addr[k] <= '0;
        p_exp[k]  <= '0;
      end
    end else if (clr) begin
      for (int k = 0; k < RD_LAT; k++) p_vld[k] <= 1'b0;
    end else begin
      p_vld[0] <= iss_vld;
      if (iss_vld) begin
        p_step[0] <= iss_step;
        p_addr[0] <= iss_addr;
        p_exp[0]  <= iss_exp;
      end
      for (int k = 1; k < RD_LAT; k++) begin
        p_vld[k] <= p_vld[k-1];
        if (p_vld[k-1]) begin
          p_step[k] <= p_step[k-1];
          p_addr[k] <= p_addr[k-1];
          p_exp[k]  <= p_exp[k-1];
        end
      end
    end
  end

  always_comb begin
    mism = p_vld[TAIL] && (rdata != p_exp[TAIL]);
    cap  = mism && !err && !clr;
    halt = mism && stop_on_error;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err       <= 1'b0;
      fail_addr <= '0;
      fail_step <= STEP_NONE;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (clr) begin
      err       <= 1'b0;
      fail_addr <= '0;
      fail_step <= STEP_NONE;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (cap) begin
      err       <= 1'b1;
      fail_addr <= p_addr[TAIL];
      fail_step <= p_step[TAIL];
      fail_exp  <= p_exp[TAIL];
      fail_got  <= rdata;
    end
  end

endmodule

// File: rtl/rfram_selftest.sv
module rfram_selftest #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter int          RD_LAT = 1,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop_on_error,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic              err,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_step,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  import rfst_pkg::*;

  logic [DATA_W-1:0] rnd;
  logic              halt;
  logic              clr;
  logic              iss_vld;
  step_t             iss_step;
  logic [DATA_W-1:0] iss_exp;
  step_t             fstep;

  rfst_lfsr #(.OUT_W(DATA_W), .SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .word (rnd)
  );

  rfst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .halt     (halt),
    .rnd      (rnd),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .iss_vld  (iss_vld),
    .iss_step (iss_step),
    .iss_exp  (iss_exp),
    .clr      (clr),
    .done     (done)
  );

  rfst_score #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_score (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .stop_on_error(stop_on_error),
    .iss_vld      (iss_vld),
    .iss_step     (iss_step),
    .iss_addr     (mem_addr),
    .iss_exp      (iss_exp),
    .rdata        (mem_rdata),
    .halt         (halt),
    .err          (err),
    .fail_addr    (fail_addr),
    .fail_step    (fstep),
    .fail_exp     (fail_exp),
    .fail_got     (fail_got)
  );

  assign fail_step = fstep;
  assign pass      = done & ~err;

endmodule

// File: rtl/rfram_selftest_chk.sv
module rfram_selftest_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic              err,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [1:0]        fail_step,
  input logic [DATA_W-1:0] fail_exp,
  input logic [DATA_W-1:0] fail_got
);

  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !mem_wr)); // R3

  AST_COLLIDE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wr) |-> ($past(mem_rd) && !$past(mem_wr) && mem_addr == $past(mem_addr))); // R2

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rd) |=> (done || (mem_rd && !mem_wr && $stable(mem_addr)))); // R2

  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rd && $past(mem_rd) && !$past(mem_wr)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && !$past(start)) |-> err); // R6

  AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(err)) |-> ($stable(fail_addr) && $stable(fail_step) && $stable(fail_exp) && $stable(fail_got))); // R6

  AST_STEP_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (fail_step != 2'd0)); // R6

  AST_PASS_MEANS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !err)); // R9

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R9

endmodule

bind rfram_selftest rfram_selftest_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .pass     (pass),
  .err      (err),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .fail_addr(fail_addr),
  .fail_step(fail_step),
  .fail_exp (fail_exp),
  .fail_got (fail_got)
);

// File: tb/rfram_selftest_test.sv
`timescale 1ns/1ps
module rfram_selftest_test;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int LAT   = 1;
  localparam int NADDR = 1 << AW;

  // {stop, poke_start, kind[1:0], lo[7:0], hi[7:0]}
  // kind: 0 none, 1 collision returns new word, 2 read flips bit 0, 3 collision write lost
  localparam logic [19:0] CASES [0:7] = '{
    {1'b0, 1'b1, 2'd0, 8'd0,   8'd0},
    {1'b1, 1'b0, 2'd2, 8'd0,   8'd0},
    {1'b1, 1'b0, 2'd0, 8'd0,   8'd0},
    {1'b0, 1'b0, 2'd2, 8'd255, 8'd255},
    {1'b0, 1'b0, 2'd1, 8'd40,  8'd50},
    {1'b1, 1'b0, 2'd3, 8'd100, 8'd100},
    {1'b0, 1'b0, 2'd2, 8'd10,  8'd20},
    {1'b1, 1'b0, 2'd1, 8'd200, 8'd201}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop_on_error = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic mem_rd, mem_wr, done, pass, err;
  logic [AW-1:0] fail_addr;
  logic [1:0] fail_step;
  logic [DW-1:0] fail_exp, fail_got;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rfram_selftest #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_on_error(stop_on_error),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .done(done), .pass(pass), .err(err),
    .fail_addr(fail_addr), .fail_step(fail_step), .fail_exp(fail_exp), .fail_got(fail_got)
  );

  // RAM model, read-first, with faults switched on by the bench
  int fault_kind = 0;
  int f_lo = 0;
  int f_hi = 0;
  logic [DW-1:0] mem [NADDR];
  logic [DW-1:0] q_pipe [LAT];

  always @(posedge clk) begin
    logic [DW-1:0] r;
    logic hit;
    hit = (int'(mem_addr) >= f_lo) && (int'(mem_addr) <= f_hi);
    r = mem[mem_addr];
    if (fault_kind == 1 && hit && mem_wr) r = mem_wdata;
    if (fault_kind == 2 && hit) r = r ^ {{(DW-1){1'b0}}, 1'b1};
    if (mem_rd) q_pipe[0] <= r;
    for (int k = 1; k < LAT; k++) q_pipe[k] <= q_pipe[k-1];
    if (mem_wr && !(fault_kind == 3 && hit && mem_rd)) mem[mem_addr] <= mem_wdata;
  end
  assign mem_rdata = q_pipe[LAT-1];

  // port monitor
  logic mon_clr = 1'b0;
  int phase, exp_addr, wr_cnt, prot_bad, lfsr_bad, quiet_bad;
  bit have_prev;
  logic [DW-1:0] cur_w1, prev_w1;
  logic [DW-1:0] ow1 [NADDR];
  logic [DW-1:0] ow2 [NADDR];

  always @(negedge clk) begin
    bit ok;
    if (mon_clr) begin
      phase = 0; exp_addr = 0; wr_cnt = 0; prot_bad = 0; lfsr_bad = 0; quiet_bad = 0;
      have_prev = 1'b0;
    end else begin
      if (done && (mem_rd || mem_wr)) quiet_bad++;
      if (mem_rd || mem_wr) begin
        case (phase)
          0:       ok = mem_wr && !mem_rd;
          2:       ok = mem_wr && mem_rd;
          default: ok = mem_rd && !mem_wr;
        endcase
        if (!ok || int'(mem_addr) != exp_addr) prot_bad++;
        if (mem_wr) wr_cnt++;
        if (phase == 0) begin
          if (have_prev && mem_wdata[DW-1:4] !== prev_w1[DW-5:0]) lfsr_bad++;
          cur_w1 = mem_wdata; prev_w1 = mem_wdata; have_prev = 1'b1;
          ow1[mem_addr] = mem_wdata;
        end
        if (phase == 2) begin
          if (mem_wdata[DW-1:2] !== cur_w1[DW-3:0]) lfsr_bad++;
          ow2[mem_addr] = mem_wdata;
        end
        if (phase == 3) begin phase = 0; exp_addr++; end
        else phase++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input int idx);
    logic [19:0] c;
    bit stop, poke, got_done, exp_err;
    int kind, lo, hi, ex_addr, ex_step, ex_exp, ex_got;
    c = CASES[idx];
    stop = c[19]; poke = c[18]; kind = int'(c[17:16]); lo = int'(c[15:8]); hi = int'(c[7:0]);
    @(posedge clk); #1;
    fault_kind = kind; f_lo = lo; f_hi = hi;
    stop_on_error = stop; start = 1'b1; mon_clr = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; mon_clr = 1'b0;
    if (poke) begin
      repeat (300) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    got_done = 1'b0;
    for (int i = 0; i < 6000 && !got_done; i++) begin
      @(negedge clk);
      got_done = done;
    end
    chk($sformatf("R9 case%0d done reached", idx), {31'd0, got_done}, 32'd1);
    // expectation derived from the words seen on the write bus
    exp_err = 1'b0; ex_addr = 0; ex_step = 0; ex_exp = 0; ex_got = 0;
    if (kind != 0) begin
      for (int a = lo; a <= hi && !exp_err; a++) begin
        if (kind == 2) begin
          exp_err = 1'b1; ex_step = 1; ex_exp = int'(ow1[a]); ex_got = int'(ow1[a] ^ 8'h01);
        end else if (ow1[a] != ow2[a]) begin
          exp_err = 1'b1;
          ex_step = (kind == 1) ? 2 : 3;
          ex_exp  = (kind == 1) ? int'(ow1[a]) : int'(ow2[a]);
          ex_got  = (kind == 1) ? int'(ow2[a]) : int'(ow1[a]);
        end
        if (exp_err) ex_addr = a;
      end
    end
    chk($sformatf("R6 case%0d err flag", idx), {31'd0, err}, {31'd0, exp_err});
    chk($sformatf("R9 case%0d pass flag", idx), {31'd0, pass}, {31'd0, !exp_err});
    if (exp_err) begin
      chk($sformatf("R6 case%0d fail_addr", idx), 32'(fail_addr), 32'(ex_addr));
      chk($sformatf("R5 case%0d fail_step", idx), 32'(fail_step), 32'(ex_step));
      chk($sformatf("R5 case%0d fail_exp", idx), 32'(fail_exp), 32'(ex_exp));
      chk($sformatf("R6 case%0d fail_got", idx), 32'(fail_got), 32'(ex_got));
    end
    chk($sformatf("R2 case%0d strobe order/address", idx), 32'(prot_bad), 32'd0);
    chk($sformatf("R4 case%0d data word sequence", idx), 32'(lfsr_bad), 32'd0);
    if (!stop || !exp_err)
      chk($sformatf("R8 case%0d write count (R10 poke=%0d)", idx, poke), 32'(wr_cnt), 32'(2*NADDR));
    else
      chk($sformatf("R7 case%0d stopped early", idx), {31'd0, wr_cnt < 2*NADDR}, 32'd1);
    repeat (6) @(negedge clk);
    chk($sformatf("R9 case%0d done held", idx), {31'd0, done}, 32'd1);
    chk($sformatf("R3 case%0d no strobe while done", idx), 32'(quiet_bad), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 err in reset", {31'd0, err}, 32'd0);
    chk("R1 strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pass after release", {31'd0, pass}, 32'd0);
    chk("R1 strobes after release", {30'd0, mem_rd, mem_wr}, 32'd0);
    // R11 follows case 1 (fail) with case 2 (clean)
    for (int i = 0; i < 8; i++) run_case(i);
    // directed: reset in the middle of a sweep
    @(posedge clk); #1 start = 1'b1; fault_kind = 2; f_lo = 5; f_hi = 5; stop_on_error = 1'b0;
    @(posedge clk); #1 start = 1'b0;
    repeat (100) @(posedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-sweep reset err", {31'd0, err}, 32'd0);
    chk("R1 mid-sweep reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk("R1 mid-sweep reset done", {31'd0, done}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 idle after reset, no strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #750000;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
    $finish;
  end

endmodule